// File: doc/BRIEF.md
# Checksum Validating Packet Steerer

This block sits in a packet pipeline with one physical input stream and one physical output stream. Every packet starts with one in-band metadata word. The five words that follow carry a 20-byte IPv4 header, and any further words are payload. The block verifies the header checksum and writes a one-byte logical-port tag into the metadata word. A downstream switch fabric matches on that tag to send good packets one way and bad packets another. The block never drops a packet, never routes a packet and never touches the payload.

Words are held in a small first-word-fall-through buffer. A packet's metadata word is not released until its verdict exists. The verdict exists once the last header word has been accepted, or earlier if the packet ends before its header is complete. After the metadata word has left, the rest of the packet streams through. Later packets keep flowing in while earlier ones drain. Every packet is handled the same way, whatever its source and whatever came before it.

Top module: `csum_steer`

## Requirements
- R1: Every word accepted at the input leaves at the output exactly once, in the same order, with its start and end markers unchanged.
- R2: Packet layout is fixed. The word flagged as start (`in_sop`) is the metadata word. The next five 32-bit words hold the 20-byte header, upper halfword first. A packet is good when the ones'-complement sum of the ten header halfwords, folded to 16 bits, equals 0xFFFF. A good packet leaves with bits [7:0] of its metadata word set to 0x00.
- R3: A complete header with any other folded sum makes the metadata tag byte (bits [7:0]) read 0x01.
- R4: A packet that ends before its fifth header word is tagged 0x01. This includes a packet made only of the metadata word.
- R5: Payload words after the header do not affect the tag. Every bit other than the tag byte, in every word, leaves unchanged.
- R6: The metadata word is not offered at the output until the packet's fifth header word, or its end word, has been accepted.
- R7: While `out_valid` is high and `out_ready` is low, the output word and its markers stay stable. Once the buffer holds FIFO_DEPTH (8) words, `in_ready` drops, and no word is lost.
- R8: After a clock edge with `rst_n` low, `out_valid` is low. Once reset is released with the buffer empty, `in_ready` is high.
- R9: Each packet's tag depends only on that packet's own header. Back-to-back packets with mixed verdicts each receive their own tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 32 | Input word |
| in_sop | input | 1 | Input word is the metadata word that starts a packet |
| in_eop | input | 1 | Input word ends the packet |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the output word |
| out_data | output | 32 | Output word, tag byte rewritten on the metadata word |
| out_sop | output | 1 | Output word starts a packet |
| out_eop | output | 1 | Output word ends a packet |

## Verification
A header accumulator that carries state from one packet into the next shows up as a wrong tag byte on the very next metadata word that leaves. A run of alternating good and bad packets sent back to back exposes it within a packet or two. A verdict queue that gets out of step with the word buffer tags the wrong packet, or lets a metadata word out early. That appears either as a tag mismatch or as `out_valid` rising before the fifth header word has gone in. Buffer pointer faults show at once as a dropped, repeated or reordered word in the compared output stream, or as `in_ready` staying high past eight held words.

// File: rtl/csum_steer_pkg.sv
// Shared constants and arithmetic for the checksum steerer.
// Assumes 16-bit ones'-complement arithmetic over the header halfwords.
package csum_steer_pkg;

    localparam int HDR_BITS = 160;
    localparam int TAG_W    = 8;
    localparam logic [TAG_W-1:0] TAG_GOOD = 8'h00;
    localparam logic [TAG_W-1:0] TAG_BAD  = 8'h01;

    // Folds a wide sum twice into a 16-bit ones'-complement result.
    function automatic logic [15:0] fold16(input logic [31:0] s);
        logic [16:0] t;
        logic [16:0] u;
        t = {1'b0, s[15:0]} + {1'b0, s[31:16]};
        u = {1'b0, t[15:0]} + {16'd0, t[16]};
        return u[15:0];
    endfunction

endpackage

// File: rtl/csum_fifo.sv
// Synchronous first-word-fall-through FIFO.
// Assumes DEPTH is a power of two, at least 2, and that the owner never
// pushes when full nor pops when empty.
module csum_fifo #(
    parameter int WIDTH = 34,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [WIDTH-1:0]         wdata,
    input  logic                     pop,
    output logic [WIDTH-1:0]         rdata,
    output logic                     empty,
    output logic                     full,
    output logic [$clog2(DEPTH):0]   level
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [AW:0]      count;

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Head word and status.
    always_comb begin
        rdata = mem[rd_ptr];
        empty = (count == '0);
        full  = (count == (AW+1)'(DEPTH));
        level = count;
    end

endmodule

// File: rtl/csum_hdr_check.sv
// Watches accepted input words and produces one verdict per packet.
// Word 0 (sop) is metadata; words 1..HDR_WORDS are the header. The verdict
// is issued with the last header word, or with an earlier end word (then bad).
// Assumes every packet begins with sop; a new sop restarts the tracking.
module csum_hdr_check
    import csum_steer_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int HDR_WORDS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat,
    input  logic [DATA_W-1:0] data,
    input  logic              sop,
    input  logic              eop,
    output logic              verdict_push,
    output logic              verdict_bad
);
    localparam int HALVES = DATA_W / 16;
    localparam int ACC_W  = 16 + $clog2(HDR_WORDS * HALVES + 1);
    localparam int IDX_W  = $clog2(HDR_WORDS + 2);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_cur;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_nx;
    logic [ACC_W-1:0] word_sum;
    logic             done_q;
    logic             done_cur;
    logic             in_hdr;
    logic             last_hdr;

    // Sum of the halfwords of the current word.
    always_comb begin
        word_sum = '0;
        for (int h = 0; h < HALVES; h++) begin
            word_sum = word_sum + ACC_W'(data[h*16 +: 16]);
        end
    end

    // Position in packet, running sum and verdict decision.
    always_comb begin
        idx_cur      = sop ? '0 : idx_q;
        done_cur     = sop ? 1'b0 : done_q;
        in_hdr       = (idx_cur != '0) && (idx_cur <= IDX_W'(HDR_WORDS));
        last_hdr     = (idx_cur == IDX_W'(HDR_WORDS));
        acc_nx       = (idx_cur == '0) ? '0 : (in_hdr ? acc_q + word_sum : acc_q);
        verdict_push = beat && !done_cur && (last_hdr || eop);
        verdict_bad  = !last_hdr || (fold16(32'(acc_nx)) != 16'hFFFF);
    end

    // State update on every accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            acc_q  <= '0;
            done_q <= 1'b0;
        end else if (beat) begin
            acc_q  <= acc_nx;
            done_q <= done_cur | verdict_push;
            idx_q  <= (idx_cur == IDX_W'(HDR_WORDS + 1)) ? idx_cur : idx_cur + 1'b1;
        end
    end

endmodule

// File: rtl/csum_steer.sv
// Checksum validating packet steerer: buffers words, holds each metadata
// word until its header verdict exists, then rewrites the tag byte.
// Assumes DATA_W divides the 160-bit header and is a multiple of 16, and
// FIFO_DEPTH is a power of two holding at least one metadata plus header.
module csum_steer
    import csum_steer_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 8,
    parameter int TAG_LSB    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop
);
    localparam int HDR_WORDS = HDR_BITS / DATA_W;
    localparam int ENTRY_W   = DATA_W + 2;
    localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1;

    logic               in_beat;
    logic               d_pop;
    logic               d_empty;
    logic               d_full;
    logic [ENTRY_W-1:0] d_rdata;
    logic [LVL_W-1:0]   d_level;
    logic               v_push;
    logic               v_bad;
    logic               v_pop;
    logic               v_empty;
    logic               v_full;
    logic [0:0]         v_rdata;
    logic [LVL_W-1:0]   v_level;
    logic               head_sop;

    csum_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_words (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (in_beat),
        .wdata ({in_sop, in_eop, in_data}),
        .pop   (d_pop),
        .rdata (d_rdata),
        .empty (d_empty),
        .full  (d_full),
        .level (d_level)
    );

    csum_hdr_check #(.DATA_W(DATA_W), .HDR_WORDS(HDR_WORDS)) u_check (
        .clk          (clk),
        .rst_n        (rst_n),
        .beat         (in_beat),
        .data         (in_data),
        .sop          (in_sop),
        .eop          (in_eop),
        .verdict_push (v_push),
        .verdict_bad  (v_bad)
    );

    csum_fifo #(.WIDTH(1), .DEPTH(FIFO_DEPTH)) u_verdicts (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (v_push),
        .wdata (v_bad),
        .pop   (v_pop),
        .rdata (v_rdata),
        .empty (v_empty),
        .full  (v_full),
        .level (v_level)
    );

    // Input acceptance.
    always_comb begin
        in_ready = !d_full && !v_full;
        in_beat  = in_valid && in_ready;
    end

    // Release gating: a metadata word waits for its verdict.
    always_comb begin
        head_sop  = d_rdata[ENTRY_W-1];
        out_valid = !d_empty && (!head_sop || !v_empty);
        d_pop     = out_valid && out_ready;
        v_pop     = d_pop && head_sop;
    end

    // Output word with the tag byte replaced on metadata words.
    always_comb begin
        out_sop  = head_sop;
        out_eop  = d_rdata[ENTRY_W-2];
        out_data = d_rdata[DATA_W-1:0];
        if (head_sop) begin
            out_data[TAG_LSB +: TAG_W] = v_rdata[0] ? TAG_BAD : TAG_GOOD;
        end
    end

endmodule

// File: rtl/csum_steer_chk.sv
// Protocol checker for csum_steer, attached by bind. Tracks its own counts
// of words, packets and resolved headers from the port activity.
module csum_steer_chk
    import csum_steer_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 8,
    parameter int TAG_LSB    = 0
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic                          in_ready,
    input logic                          in_sop,
    input logic                          in_eop,
    input logic                          out_valid,
    input logic                          out_ready,
    input logic [DATA_W-1:0]             out_data,
    input logic                          out_sop,
    input logic                          out_eop,
    input logic [$clog2(FIFO_DEPTH):0]   d_level,
    input logic [$clog2(FIFO_DEPTH):0]   v_level
);
    localparam int HDR_WORDS = HDR_BITS / DATA_W;
    localparam int IDX_W     = $clog2(HDR_WORDS + 2);

    logic             in_beat;
    logic             out_beat;
    logic [31:0]      occ;
    logic [31:0]      in_pkts;
    logic [31:0]      out_pkts;
    logic [31:0]      resolved;
    logic [31:0]      released;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_cur;
    logic             done_q;
    logic             done_cur;
    logic             resolve_ev;

    initial begin
        assert (FIFO_DEPTH >= HDR_WORDS + 1)
            else $error("buffer too shallow to resolve a header");
    end

    // Handshakes and header-resolution events seen at the ports.
    always_comb begin
        in_beat    = in_valid && in_ready;
        out_beat   = out_valid && out_ready;
        idx_cur    = in_sop ? '0 : idx_q;
        done_cur   = in_sop ? 1'b0 : done_q;
        resolve_ev = in_beat && !done_cur &&
                     ((idx_cur == IDX_W'(HDR_WORDS)) || in_eop);
    end

    // Reference counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ      <= '0;
            in_pkts  <= '0;
            out_pkts <= '0;
            resolved <= '0;
            released <= '0;
            idx_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            occ <= occ + 32'(in_beat) - 32'(out_beat);
            if (in_beat && in_sop)   in_pkts  <= in_pkts + 1;
            if (out_beat && out_sop) out_pkts <= out_pkts + 1;
            if (resolve_ev)          resolved <= resolved + 1;
            if (out_beat && out_sop) released <= released + 1;
            if (in_beat) begin
                done_q <= done_cur | resolve_ev;
                idx_q  <= (idx_cur == IDX_W'(HDR_WORDS + 1)) ? idx_cur : idx_cur + 1'b1;
            end
        end
    end

    p_reset_r8: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) &&
                                    $stable(out_sop) && $stable(out_eop));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= 32'(FIFO_DEPTH));

    p_tag_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sop |-> (out_data[TAG_LSB +: TAG_W] == TAG_GOOD) ||
                                 (out_data[TAG_LSB +: TAG_W] == TAG_BAD));

    p_resolved_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sop |-> resolved > released);

    p_packet_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sop |-> out_pkts < in_pkts);

    p_verdict_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        v_level <= d_level);

endmodule

bind csum_steer csum_steer_chk #(
    .DATA_W     (DATA_W),
    .FIFO_DEPTH (FIFO_DEPTH),
    .TAG_LSB    (TAG_LSB)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .d_level   (d_level),
    .v_level   (v_level)
);

// File: tb/csum_steer_test.sv
// Sweep bench: packet lengths, corrupted halfwords, stall patterns.
module csum_steer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        out_sop;
    logic        out_eop;

    int checks = 0;
    int failures = 0;
    int wr_idx = 0;
    int rd_idx = 0;
    int rdy_mode = 0;
    int gap_mode = 0;
    bit finished = 0;
    bit run_out = 0;

    logic [33:0] exp_word [0:4095];
    string       exp_req  [0:4095];

    always #4 clk = ~clk;

    csum_steer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop)
    );

    task automatic check(input bit ok, input string req, input logic [33:0] act,
                         input logic [33:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] bfold(input logic [31:0] s);
        logic [31:0] t;
        t = s;
        while (t[31:16] != 16'd0) t = {16'd0, t[15:0]} + {16'd0, t[31:16]};
        return t[15:0];
    endfunction

    // One word through the input handshake.
    task automatic send_word(input logic [31:0] d, input logic s, input logic e);
        bit taken = 0;
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
        while (!taken) begin
            #1 taken = in_ready;
            @(posedge clk);
            if (!taken) @(negedge clk);
        end
        #1 in_valid = 1'b0;
    endtask

    // Builds, records and sends one packet. pause_kind 1: R6 probe, 2: R7 probe.
    task automatic send_pkt(input int n_hdr, input int n_pay, input int corrupt,
                            input int seed, input int pause_at, input int pause_kind);
        logic [31:0] w [0:15];
        logic [31:0] sum;
        int n;
        bit bad;
        n = 1 + n_hdr + n_pay;
        w[0] = 32'h5A0000A5 ^ (32'(seed) << 8);
        for (int i = 1; i <= 8; i++) w[i] = (32'h9E3779B9 * 32'(seed * 16 + i + 1)) ^ 32'h12345678;
        w[3][15:0] = 16'h0000;
        sum = 0;
        for (int i = 1; i <= 5; i++) sum = sum + 32'(w[i][31:16]) + 32'(w[i][15:0]);
        w[3][15:0] = ~bfold(sum);
        if (corrupt >= 0) w[1 + corrupt / 2] = w[1 + corrupt / 2] ^
            (32'd1 << (((corrupt % 2) == 0 ? 16 : 0) + (corrupt % 16)));
        bad = (n_hdr < 5) || (corrupt >= 0);
        for (int i = 0; i < n; i++) begin
            logic [31:0] ew;
            ew = w[i];
            if (i == 0) ew[7:0] = bad ? 8'h01 : 8'h00;
            exp_word[wr_idx] = {i == 0, i == n - 1, ew};
            if (i == 0) exp_req[wr_idx] = (n_hdr < 5) ? "R4 short tag" :
                                          (bad ? "R3 bad tag /R9" : "R2 good tag /R9");
            else        exp_req[wr_idx] = "R1 order /R5 unchanged";
            wr_idx++;
        end
        for (int i = 0; i < n; i++) begin
            if (i == pause_at && pause_kind == 1) begin
                repeat (6) @(negedge clk);
                #1 check(out_valid == 1'b0, "R6 metadata held", 34'(out_valid), 34'd0);
            end
            if (i == pause_at && pause_kind == 2) begin
                repeat (3) @(negedge clk);
                #1 check(in_ready == 1'b0, "R7 ready drops when full", 34'(in_ready), 34'd0);
                rdy_mode = 0;
            end
            send_word(w[i], i == 0, i == n - 1);
            if (gap_mode != 0 && (i % 4) == 3) @(negedge clk);
        end
    endtask

    task automatic drain();
        int guard = 0;
        while (rd_idx != wr_idx && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check(rd_idx == wr_idx, "R1 all words delivered", 34'(rd_idx), 34'(wr_idx));
    endtask

    // Output side: drives out_ready, compares words, checks stalls.
    initial begin
        int cyc = 0;
        bit stalled = 0;
        logic [33:0] held = '0;
        wait (run_out);
        forever begin
            logic [33:0] act;
            @(negedge clk);
            cyc++;
            out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? ((cyc % 3) != 0) : 1'b0;
            #1;
            act = {out_sop, out_eop, out_data};
            if (stalled) check(out_valid && act == held, "R7 stall hold", act, held);
            stalled = out_valid && !out_ready;
            held = act;
            if (out_valid && out_ready) begin
                if (rd_idx < wr_idx)
                    check(act == exp_word[rd_idx], exp_req[rd_idx], act, exp_word[rd_idx]);
                else
                    check(1'b0, "R1 unexpected word", act, 34'd0);
                rd_idx++;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R8 reset output idle", 34'(out_valid), 34'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R8 ready after reset", 34'(in_ready), 34'd1);
        check(out_valid == 1'b0, "R8 empty after reset", 34'(out_valid), 34'd0);
        run_out = 1;

        // R6: stop after metadata and four header words.
        rdy_mode = 0;
        send_pkt(5, 1, -1, 1, 5, 1);
        drain();

        // R7: nothing drains, nine-word packet, probe after eight.
        rdy_mode = 2;
        send_pkt(5, 3, -1, 2, 8, 2);
        drain();

        // R2 R3 R4 R5 R9: sweep lengths and corruptions under stall patterns.
        for (int m = 0; m < 4; m++) begin
            rdy_mode = m % 2;
            gap_mode = m / 2;
            for (int h = 0; h <= 5; h++) begin
                for (int p = 0; p <= ((h == 5) ? 2 : 0); p++) begin
                    for (int c = -1; c <= ((h == 5) ? 9 : -1); c++) begin
                        send_pkt(h, p, c, m * 100 + h * 20 + p * 11 + c + 2, -1, 0);
                    end
                end
            end
            drain();
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule